// File: doc/BRIEF.md
# Reciprocal-Multiply Floating Divider

This block divides an unsigned integer numerator by a small unsigned integer denominator without any iteration. The denominator indexes a table of reciprocal significands that is computed when the design is elaborated. A small piece of logic derives a shift count from the same denominator. The numerator is then multiplied by the 8-bit significand. The result is a floating value: an integer product `prod` and a scale `scale`, so the quotient is `prod × 2^-scale`. The scale equals the significand width plus the shift count.

The reciprocal part always takes two cycles. A parameter selects the multiply part: either a single registered multiply, for a total latency of 3 cycles, or a three-stage split multiply for a shorter clock period, for a total latency of 5 cycles. A new division is accepted on every clock in both variants. A zero denominator does not stop the stream. It travels with its operand and comes out flagged by `err`, with a zero product.

Top module: `recip_mul_div`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `prod`, `scale` and `err` are all 0.
- R2: For a valid result with denominator X in 1..63, `scale` = 8 + S. S is the bit index of the highest set bit of X−1, and S = 0 when X is 1 or 2, so S = 0,1,2,3,4,5 for X in [1,2],[3,4],[5,8],[9,16],[17,32],[33,63].
- R3: For a nonzero X, the significand is G = floor((2^(9+S) + X) / (2X)), which is 2^(8+S)/X rounded to nearest with ties upward. G is limited to 255, which applies only to X = 1. `prod` equals exactly N × G.
- R4: For a nonzero X, `prod × 2^-scale` differs from N/X by no more than (N/X)/128.
- R5: With `PIPE_MUL` = 0, a result appears 3 cycles after its operands are sampled. With `PIPE_MUL` = 1, it appears 5 cycles after. `out_valid` repeats `in_valid` delayed by that latency.
- R6: Operands presented on consecutive cycles each produce their own result on consecutive cycles, with no stall.
- R7: A valid operand pair with X = 0 yields `err` = 1, `prod` = 0 and `scale` = 8 in its result cycle. Every valid result with X ≠ 0 has `err` = 0.
- R8: A cycle with `in_valid` low produces a cycle with `out_valid` low after the latency, and it does not disturb the results on either side of it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands on `num`/`den` are valid this cycle |
| num | input | 8 | Unsigned numerator N |
| den | input | 6 | Unsigned denominator X |
| out_valid | output | 1 | Result outputs are valid |
| prod | output | 16 | Product N × G, the quotient's integer part before scaling |
| scale | output | 4 | Negative power-of-two exponent of the quotient |
| err | output | 1 | Result came from a zero denominator |

## Verification
Every numerator from 0 to 255 is divided by every denominator from 0 to 63. Both multiply variants run side by side on the same stream. The sweep checks exact products, which detects any wrong table entry, wrong rounding or wrong shift boundary. It also checks the relative error bound, which detects scale mistakes that an exact-product match on its own could hide. Idle cycles are inserted at a fixed stride among long runs of back-to-back operands. This tells a correct fixed latency apart from a stream that slips, duplicates or drops a result. The zero-denominator rows confirm that the error flag stays aligned with its own operands.

// File: rtl/recip_mul_div.sv
module recip_mul_div #(
  parameter int NUM_W    = 8,
  parameter int DEN_W    = 6,
  parameter int SIG_W    = 8,
  parameter int PIPE_MUL = 0
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  in_valid,
  input  logic [NUM_W-1:0]                      num,
  input  logic [DEN_W-1:0]                      den,
  output logic                                  out_valid,
  output logic [NUM_W+SIG_W-1:0]                prod,
  output logic [$clog2(SIG_W+DEN_W)-1:0]        scale,
  output logic                                  err
);
  localparam int SH_W  = $clog2(DEN_W);
  localparam int SC_W  = $clog2(SIG_W + DEN_W);
  localparam int PR_W  = NUM_W + SIG_W;
  localparam int DEPTH = 1 << DEN_W;
  localparam int HW    = SIG_W / 2;
  localparam int LO_W  = NUM_W + HW;
  localparam int HI_W  = NUM_W + SIG_W - HW;

  function automatic logic [SH_W-1:0] shift_of(input logic [DEN_W-1:0] x);
    logic [DEN_W-1:0] m;
    shift_of = '0;
    m = x - DEN_W'(1);
    if (x > DEN_W'(1))
      for (int i = 0; i < DEN_W; i++)
        if (m[i]) shift_of = SH_W'(i);
  endfunction

  function automatic logic [SIG_W-1:0] sig_of(input int x);
    longint p, q, lim;
    if (x == 0) return '0;
    lim = (longint'(1) << SIG_W) - 1;
    p = longint'(1) << (SIG_W + 1 + int'(shift_of(DEN_W'(x))));
    q = (p + longint'(x)) / (2 * longint'(x));
    if (q > lim) q = lim;
    return SIG_W'(q);
  endfunction

  logic [SIG_W-1:0] rom [DEPTH];
  for (genvar g = 0; g < DEPTH; g++) begin : g_rom
    assign rom[g] = sig_of(g);
  end

  logic             v1, v2, e2;
  logic [NUM_W-1:0] n1, n2;
  logic [DEN_W-1:0] d1;
  logic [SIG_W-1:0] sig2;
  logic [SH_W-1:0]  sh2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      n1 <= '0;
      d1 <= '0;
    end else begin
      v1 <= in_valid;
      n1 <= num;
      d1 <= den;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v2   <= 1'b0;
      e2   <= 1'b0;
      n2   <= '0;
      sig2 <= '0;
      sh2  <= '0;
    end else begin
      v2   <= v1;
      e2   <= (d1 == '0);
      n2   <= (d1 == '0) ? '0 : n1;
      sig2 <= rom[d1];
      sh2  <= shift_of(d1);
    end
  end

  logic            vq, eq;
  logic [PR_W-1:0] pq;
  logic [SH_W-1:0] sq;

  if (PIPE_MUL == 0) begin : g_single
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vq <= 1'b0;
        eq <= 1'b0;
        pq <= '0;
        sq <= '0;
      end else begin
        vq <= v2;
        eq <= e2;
        pq <= PR_W'(n2) * PR_W'(sig2);
        sq <= sh2;
      end
    end
  end else begin : g_split
    logic            va, vb, ea, eb;
    logic [SH_W-1:0] sa, sb;
    logic [LO_W-1:0] plo;
    logic [HI_W-1:0] phi;
    logic [PR_W-1:0] psum;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        va  <= 1'b0;
        ea  <= 1'b0;
        sa  <= '0;
        plo <= '0;
        phi <= '0;
      end else begin
        va  <= v2;
        ea  <= e2;
        sa  <= sh2;
        plo <= LO_W'(n2) * LO_W'(sig2[HW-1:0]);
        phi <= HI_W'(n2) * HI_W'(sig2[SIG_W-1:HW]);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vb   <= 1'b0;
        eb   <= 1'b0;
        sb   <= '0;
        psum <= '0;
      end else begin
        vb   <= va;
        eb   <= ea;
        sb   <= sa;
        psum <= PR_W'(plo) + (PR_W'(phi) << HW);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vq <= 1'b0;
        eq <= 1'b0;
        pq <= '0;
        sq <= '0;
      end else begin
        vq <= vb;
        eq <= eb;
        pq <= psum;
        sq <= sb;
      end
    end
  end

  assign out_valid = vq;
  assign err       = eq;
  assign prod      = pq;
  assign scale     = vq ? SC_W'(SIG_W) + SC_W'(sq) : '0;
endmodule

module recip_mul_div_chk #(
  parameter int NUM_W    = 8,
  parameter int DEN_W    = 6,
  parameter int SIG_W    = 8,
  parameter int PIPE_MUL = 0
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           in_valid,
  input logic [DEN_W-1:0]               den,
  input logic                           out_valid,
  input logic [NUM_W+SIG_W-1:0]         prod,
  input logic [$clog2(SIG_W+DEN_W)-1:0] scale,
  input logic                           err
);
  localparam int LAT = (PIPE_MUL == 0) ? 3 : 5;

  // R5
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##LAT out_valid);

  // R8
  bubble_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##LAT !out_valid);

  // R7
  zero_den_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && den == '0) |-> ##LAT (out_valid && err && prod == '0));

  // R2
  scale_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (scale >= SIG_W && scale <= SIG_W + DEN_W - 1));
endmodule

bind recip_mul_div recip_mul_div_chk #(
  .NUM_W(NUM_W), .DEN_W(DEN_W), .SIG_W(SIG_W), .PIPE_MUL(PIPE_MUL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .den(den),
  .out_valid(out_valid), .prod(prod), .scale(scale), .err(err)
);

// File: tb/sim_recip_mul_div.sv
module sim_recip_mul_div;
  localparam int HLEN = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  num = '0;
  logic [5:0]  den = '0;

  logic        ov0, er0, ov1, er1;
  logic [15:0] pr0, pr1;
  logic [3:0]  sc0, sc1;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  bit hv [HLEN];
  int hn [HLEN];
  int hd [HLEN];

  always #10 clk = ~clk;

  recip_mul_div #(.PIPE_MUL(0)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .num(num), .den(den),
    .out_valid(ov0), .prod(pr0), .scale(sc0), .err(er0));

  recip_mul_div #(.PIPE_MUL(1)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .num(num), .den(den),
    .out_valid(ov1), .prod(pr1), .scale(sc1), .err(er1));

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_out(input string tag, input int lat, input int t,
                           input logic ov, input logic [15:0] pr,
                           input logic [3:0] sc, input logic er);
    int s, g, x, n;
    longint lhs, rhs;
    int src;
    src = t - lat;
    if (src < 0 || !hv[src]) begin
      // R5, R8: no result in this slot
      chk(ov == 1'b0, "R8", {tag, " out_valid idle"}, longint'(ov), 0);
      return;
    end
    // R5, R6: one result per accepted operand, at fixed latency
    chk(ov == 1'b1, "R5", {tag, " out_valid"}, longint'(ov), 1);
    x = hd[src];
    n = hn[src];
    if (x == 0) begin
      chk(er == 1'b1, "R7", {tag, " err on zero den"}, longint'(er), 1);
      chk(pr == 16'd0, "R7", {tag, " prod on zero den"}, longint'(pr), 0);
      chk(sc == 4'd8, "R7", {tag, " scale on zero den"}, longint'(sc), 8);
      return;
    end
    s = 0;
    while (x > (2 << s)) s++;
    g = ((1 << (9 + s)) + x) / (2 * x);
    if (g > 255) g = 255;
    chk(er == 1'b0, "R7", {tag, " err clear"}, longint'(er), 0);
    chk(sc == 4'(8 + s), "R2", {tag, " scale"}, longint'(sc), 8 + s);
    chk(pr == 16'(n * g), "R3", {tag, " prod"}, longint'(pr), n * g);
    lhs = longint'(pr) * x - (longint'(n) << sc);
    if (lhs < 0) lhs = -lhs;
    rhs = longint'(n) << sc;
    chk(lhs * 128 <= rhs, "R4", {tag, " relative error"}, lhs * 128, rhs);
  endtask

  task automatic step_checks(input int t);
    check_out("pipe0", 3, t, ov0, pr0, sc0, er0);
    check_out("pipe1", 5, t, ov1, pr1, sc1, er1);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int t;
    t = 0;
    for (int i = 0; i < HLEN; i++) hv[i] = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      // R1: reset holds every output at zero
      chk(ov0 == 0 && pr0 == 0 && sc0 == 0 && er0 == 0, "R1", "u0 reset outputs",
          longint'({ov0, pr0, sc0, er0}), 0);
      chk(ov1 == 0 && pr1 == 0 && sc1 == 0 && er1 == 0, "R1", "u1 reset outputs",
          longint'({ov1, pr1, sc1, er1}), 0);
    end
    rst_n = 1'b1;
    for (int d = 0; d < 64; d++) begin
      for (int n = 0; n < 256; n++) begin
        if (t % 13 == 12) begin
          // R8: bubble between back-to-back operands
          step_checks(t);
          in_valid = 1'b0;
          hv[t] = 0;
          t++;
          @(negedge clk);
        end
        step_checks(t);
        in_valid = 1'b1;
        num = 8'(n);
        den = 6'(d);
        hv[t] = 1;
        hn[t] = n;
        hd[t] = d;
        t++;
        @(negedge clk);
      end
    end
    for (int k = 0; k < 8; k++) begin
      step_checks(t);
      in_valid = 1'b0;
      hv[t] = 0;
      t++;
      @(negedge clk);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule